// File: doc/BRIEF.md
# Programmable Tick Timer

The block is a 32-bit up-counter that advances once for each cycle in which a clock-enable tick input is high. It is controlled through two words on a small special-register bus. A control word holds a 28-bit compare period, a pending flag, an interrupt enable and a 2-bit mode. A count word holds the live counter value. When the low 28 bits of the counter equal the period on an advancing tick, a match occurs and the pending flag is set. The interrupt output is high while pending and enable are both set.

There are four modes: off, restart (the counter returns to zero on a match), one-shot (the counter freezes on a match) and free-run (the counter keeps going and wraps at 32 bits). Counting begins when software writes a mode that differs from the current one and is not off. It ends when software writes off, or when a one-shot match occurs. Writing the control word with the pending bit at 1 leaves the pending flag as it was, so the other fields can be updated without losing an event. Writing it with the pending bit at 0 acknowledges the event and clears the flag.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0 (mode off, period 0, enable 0, pending 0), the count reads 0 and irq is 0.
- R2: The control word is at address (10<<11)+0 = 0x5000 and the count word at (10<<11)+1 = 0x5001. bus_rdata is a combinational function of bus_addr. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: Control word layout: period in bits [27:0], pending in bit 28, interrupt enable in bit 29, mode in bits [31:30] (00 off, 01 restart, 10 one-shot, 11 free-run). Period, enable and mode read back as written one cycle after the write.
- R4: While counting, each cycle with tick high and no match raises the count by 1. A cycle with tick low leaves the count unchanged.
- R5: A control write whose mode differs from the current mode starts counting if the new mode is not off, and stops counting if it is off. A control write with the same mode leaves the counting state unchanged, so a stopped one-shot stays stopped. While stopped, the count does not move.
- R6: A match is a cycle with tick high, counting active, no count write, and count[27:0] equal to the period. A match sets pending. In restart mode a match sets the count to 0.
- R7: In one-shot mode a match leaves the count at its value and stops counting.
- R8: In free-run mode a match still raises the count by 1, and the count wraps from 0xFFFFFFFF to 0.
- R9: A control write with bit 28 at 1 keeps the pending flag unchanged. A control write with bit 28 at 0 clears it.
- R10: When a match and a pending-clearing control write fall in the same cycle, pending ends up set.
- R11: irq is high exactly when pending and interrupt enable are both set.
- R12: A count write loads the count from bus_wdata on the next edge. It takes priority over a tick in the same cycle, and that cycle produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one advance per high cycle |
| bus_wr | input | 1 | Register write strobe, one write per high cycle |
| bus_addr | input | 16 | Register address for writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Timer interrupt, pending AND enable |

## Verification
The assertions assume that tick, bus_wr, bus_addr and bus_wdata are known and stable around every rising clock edge once reset is released, and that each cycle with bus_wr high is one complete write. The properties relate the write and tick strobes of a cycle to the counter and flags of the next cycle. They therefore rely on no write being split across cycles and on the tick input being free of glitches. The bench changes every input only at falling edges and raises bus_wr for exactly one cycle per write. It deliberately makes a tick coincide with a control write and with a count write, so that the two priority rules are exercised inside these assumptions.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_DW      = 32;
  localparam int TT_PW      = 28;
  localparam int TT_PEND    = TT_PW;
  localparam int TT_IE      = TT_PW + 1;
  localparam int TT_MODE_LO = TT_PW + 2;

  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_FREE    = 2'b11
  } tt_mode_e;

  // compare of the low counter bits against the period
  function automatic logic tt_hit(input logic [TT_PW-1:0] cnt_lo,
                                  input logic [TT_PW-1:0] per);
    return cnt_lo == per;
  endfunction

  // counter value after a match, per mode
  function automatic logic [TT_DW-1:0] tt_after_hit(input tt_mode_e m,
                                                    input logic [TT_DW-1:0] cnt);
    case (m)
      TT_RESTART: return '0;
      TT_ONESHOT: return cnt;
      default:    return cnt + 1'b1;
    endcase
  endfunction

  function automatic logic [TT_DW-1:0] tt_pack(input tt_mode_e m, input logic ie,
                                               input logic pend,
                                               input logic [TT_PW-1:0] per);
    return {m, ie, pend, per};
  endfunction
endpackage

// File: rtl/tt_bus_dec.sv
module tt_bus_dec #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = '0
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctrl_sel,
  output logic              cnt_sel,
  output logic              ctrl_wr,
  output logic              cnt_wr
);
  assign ctrl_sel = (bus_addr == CTRL_ADDR);
  assign cnt_sel  = (bus_addr == CNT_ADDR);
  assign ctrl_wr  = bus_wr && ctrl_sel;
  assign cnt_wr   = bus_wr && cnt_sel;
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [TT_DW-1:0]  wdata,
  input  logic              match_ev,
  input  logic              stop_ev,
  output tt_mode_e          mode_q,
  output logic              ie_q,
  output logic              pend_q,
  output logic [TT_PW-1:0]  period_q,
  output logic              run_q,
  output logic              mode_chg
);
  tt_mode_e new_mode;

  assign new_mode = tt_mode_e'(wdata[TT_DW-1:TT_MODE_LO]);
  assign mode_chg = ctrl_wr && (new_mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= TT_OFF;
      ie_q     <= 1'b0;
      period_q <= '0;
    end else if (ctrl_wr) begin
      mode_q   <= new_mode;
      ie_q     <= wdata[TT_IE];
      period_q <= wdata[TT_PW-1:0];
    end
  end

  // a match in the same cycle outranks an acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pend_q <= 1'b0;
    else if (match_ev)                    pend_q <= 1'b1;
    else if (ctrl_wr && !wdata[TT_PEND])  pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (mode_chg) run_q <= (new_mode != TT_OFF);
    else if (stop_ev)  run_q <= 1'b0;
  end
endmodule

// File: rtl/tt_count.sv
module tt_count
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  tt_mode_e          mode,
  input  logic [TT_PW-1:0]  period,
  input  logic              cnt_wr,
  input  logic [TT_DW-1:0]  wdata,
  output logic [TT_DW-1:0]  count_q,
  output logic              match_ev,
  output logic              stop_ev
);
  logic adv;

  assign adv      = tick && run && !cnt_wr;
  assign match_ev = adv && tt_hit(count_q[TT_PW-1:0], period);
  assign stop_ev  = match_ev && (mode == TT_ONESHOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (cnt_wr)   count_q <= wdata;
    else if (match_ev) count_q <= tt_after_hit(mode, count_q);
    else if (adv)      count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int GROUP_SHIFT = 11,
  parameter int GROUP_ID    = 10,
  parameter int CTRL_IDX    = 0,
  parameter int CNT_IDX     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TT_DW-1:0]  bus_wdata,
  output logic [TT_DW-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((GROUP_ID << GROUP_SHIFT) + CTRL_IDX);
  localparam logic [ADDR_W-1:0] CNT_ADDR  = ADDR_W'((GROUP_ID << GROUP_SHIFT) + CNT_IDX);

  logic              ctrl_sel, cnt_sel, ctrl_wr, cnt_wr;
  logic              match_ev, stop_ev, mode_chg;
  logic              run_q, pend_q, ie_q;
  tt_mode_e          mode_q;
  logic [TT_PW-1:0]  period_q;
  logic [TT_DW-1:0]  count_q;

  tt_bus_dec #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .CNT_ADDR (CNT_ADDR)
  ) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ctrl_sel(ctrl_sel),
    .cnt_sel (cnt_sel),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr)
  );

  tt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .wdata   (bus_wdata),
    .match_ev(match_ev),
    .stop_ev (stop_ev),
    .mode_q  (mode_q),
    .ie_q    (ie_q),
    .pend_q  (pend_q),
    .period_q(period_q),
    .run_q   (run_q),
    .mode_chg(mode_chg)
  );

  tt_count u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run_q),
    .mode    (mode_q),
    .period  (period_q),
    .cnt_wr  (cnt_wr),
    .wdata   (bus_wdata),
    .count_q (count_q),
    .match_ev(match_ev),
    .stop_ev (stop_ev)
  );

  always_comb begin
    if (ctrl_sel)     bus_rdata = tt_pack(mode_q, ie_q, pend_q, period_q);
    else if (cnt_sel) bus_rdata = count_q;
    else              bus_rdata = '0;
  end

  assign irq = pend_q && ie_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic [TT_DW-1:0] wdata,
  input logic             match_ev,
  input logic             mode_chg,
  input logic             run_q,
  input logic             pend_q,
  input tt_mode_e         mode_q,
  input logic [TT_DW-1:0] count_q,
  input logic             irq
);
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(wdata));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !(tick && run_q)) |=> $stable(count_q));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && tick && run_q && !match_ev) |=> count_q == $past(count_q) + 32'd1);

  p_match_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |-> (tick && run_q && !cnt_wr));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode_q == TT_RESTART) |=> count_q == '0);

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode_q == TT_ONESHOT && !mode_chg) |=> (!run_q && $stable(count_q)));

  p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> mode_q != TT_OFF);

  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> pend_q);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[TT_PEND] && !match_ev) |=> !pend_q);

  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[TT_PEND] && !match_ev) |=> pend_q == $past(pend_q));

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(match_ev) || $past(ctrl_wr)));
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .ctrl_wr (ctrl_wr),
  .cnt_wr  (cnt_wr),
  .wdata   (bus_wdata),
  .match_ev(match_ev),
  .mode_chg(mode_chg),
  .run_q   (run_q),
  .pend_q  (pend_q),
  .mode_q  (mode_q),
  .count_q (count_q),
  .irq     (irq)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_CTRL = 16'h5000;
  localparam logic [15:0] A_CNT  = 16'h5001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [1:0] m, input logic ie,
                                     input logic pend, input logic [27:0] per);
    return {m, ie, pend, per};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic with_tick);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0; bus_addr = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", A_CTRL, 32'h0);
    chk_reg("R1 count", A_CNT, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(16'h5002, 32'hFFFF_FFFF, 1'b0);
    wr(16'h4800, 32'hFFFF_FFFF, 1'b0);
    chk_reg("R2 ctrl untouched", A_CTRL, 32'h0);
    chk_reg("R2 count untouched", A_CNT, 32'h0);
    chk_reg("R2 unmapped read", 16'h5002, 32'h0);
  endtask

  task automatic t_off_mode;
    wr(A_CNT, 32'd5, 1'b0);
    chk_reg("R12 load", A_CNT, 32'd5);
    ticks(4);
    chk_reg("R5 off holds", A_CNT, 32'd5);
  endtask

  task automatic t_restart;
    wr(A_CNT, 32'd0, 1'b0);
    wr(A_CTRL, mk(2'b01, 1'b1, 1'b1, 28'd3), 1'b0);
    chk_reg("R3 readback, R9 keep 0", A_CTRL, 32'h6000_0003);
    ticks(3);
    chk_reg("R4 count", A_CNT, 32'd3);
    chk("R11 no irq", {31'b0, irq}, 32'h0);
    idle(3);
    chk_reg("R4 tick low holds", A_CNT, 32'd3);
    ticks(1);
    chk_reg("R6 restart to 0", A_CNT, 32'd0);
    chk_reg("R6 pend set", A_CTRL, 32'h7000_0003);
    chk("R11 irq", {31'b0, irq}, 32'h1);
    ticks(4);
    chk_reg("R6 second period", A_CNT, 32'd0);
    ticks(2);
    chk_reg("R4 mid period", A_CNT, 32'd2);
  endtask

  task automatic t_pending;
    wr(A_CTRL, mk(2'b01, 1'b1, 1'b1, 28'd3), 1'b0);
    chk("R9 keep 1 irq", {31'b0, irq}, 32'h1);
    ticks(1);
    chk_reg("R5 same mode keeps running", A_CNT, 32'd3);
    wr(A_CTRL, mk(2'b01, 1'b0, 1'b1, 28'd3), 1'b0);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    chk_reg("R11 pend still set", A_CTRL, 32'h5000_0003);
    wr(A_CTRL, mk(2'b01, 1'b0, 1'b0, 28'd3), 1'b0);
    chk_reg("R9 clear", A_CTRL, 32'h4000_0003);
  endtask

  task automatic t_oneshot;
    wr(A_CNT, 32'd0, 1'b0);
    wr(A_CTRL, mk(2'b10, 1'b1, 1'b0, 28'd2), 1'b0);
    ticks(2);
    chk_reg("R7 before match", A_CNT, 32'd2);
    ticks(1);
    chk_reg("R7 held at match", A_CNT, 32'd2);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    ticks(5);
    chk_reg("R7 stopped", A_CNT, 32'd2);
    wr(A_CTRL, mk(2'b10, 1'b1, 1'b0, 28'd2), 1'b0);
    chk("R9 ack", {31'b0, irq}, 32'h0);
    ticks(3);
    chk_reg("R5 same mode no restart", A_CNT, 32'd2);
    wr(A_CNT, 32'd0, 1'b0);
    ticks(2);
    chk_reg("R5 stopped after load", A_CNT, 32'd0);
  endtask

  task automatic t_free;
    wr(A_CTRL, mk(2'b11, 1'b0, 1'b0, 28'd1), 1'b0);
    ticks(1);
    chk_reg("R5 started", A_CNT, 32'd1);
    ticks(1);
    chk_reg("R8 keeps counting", A_CNT, 32'd2);
    chk_reg("R8 pend", A_CTRL, 32'hD000_0001);
    ticks(1);
    chk_reg("R8 after", A_CNT, 32'd3);
    wr(A_CTRL, 32'hCFFF_FFFF, 1'b0);
    wr(A_CNT, 32'hFFFF_FFFE, 1'b0);
    ticks(1);
    chk_reg("R8 near top", A_CNT, 32'hFFFF_FFFF);
    chk_reg("R8 no match yet", A_CTRL, 32'hCFFF_FFFF);
    ticks(1);
    chk_reg("R8 wrap", A_CNT, 32'h0);
    chk_reg("R8 wrap match", A_CTRL, 32'hDFFF_FFFF);
  endtask

  task automatic t_collide;
    wr(A_CTRL, mk(2'b01, 1'b1, 1'b0, 28'd0), 1'b0);
    chk_reg("R6 count at 0", A_CNT, 32'd0);
    wr(A_CTRL, mk(2'b01, 1'b1, 1'b0, 28'd0), 1'b1);
    chk_reg("R10 match beats clear", A_CTRL, 32'h7000_0000);
    chk("R10 irq", {31'b0, irq}, 32'h1);
    wr(A_CTRL, mk(2'b01, 1'b1, 1'b0, 28'd0), 1'b0);
    chk_reg("R9 clear", A_CTRL, 32'h6000_0000);
    wr(A_CNT, 32'd7, 1'b1);
    chk_reg("R12 load beats tick", A_CNT, 32'd7);
    chk_reg("R12 no match", A_CTRL, 32'h6000_0000);
  endtask

  task automatic t_stop;
    wr(A_CTRL, mk(2'b00, 1'b0, 1'b0, 28'd0), 1'b0);
    ticks(3);
    chk_reg("R5 off stops", A_CNT, 32'd7);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unmapped();
    t_off_mode();
    t_restart();
    t_pending();
    t_oneshot();
    t_free();
    t_collide();
    t_stop();
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule